// File: doc/BRIEF.md
# UART Interrupt Controller

This block gathers the interrupt causes of a UART and turns them into one interrupt line. The transmit and receive paths drive a vector of cause inputs. A cause that is high on a clock edge sets its bit in a sticky status register. The bit stays set until software writes a one to it.

A mask register decides which status bits may raise the interrupt. Software never writes the mask directly. It writes ones to a set address to enable bits and ones to a clear address to disable them, and both of those addresses read back as zero.

A separate live view shows the present level of the four FIFO conditions, whether or not they are masked. The bus side is a plain write strobe with an address and data, plus a combinational read port decoded from the same address.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the mask register, the status register and `irq_o` are all zero.
- R2: A write to address 0 sets every mask bit whose data bit is one. Mask bits whose data bit is zero keep their value, and only writes to addresses 0 and 1 change the mask.
- R3: A write to address 1 clears every mask bit whose data bit is one. Mask bits whose data bit is zero keep their value.
- R4: A read of address 0 or address 1 returns zero. A read of address 2 returns the mask, and a read of address 3 returns the status.
- R5: Only data bits 12:0 of a write have any effect. Bits 31:13 are ignored, and they read back as zero from every address.
- R6: A status bit is set on any cycle where its cause input is high, and it stays set after the cause drops. The cause bits are:
  - bit 0: RX trigger
  - bit 1: RX empty
  - bit 2: RX full
  - bit 3: TX empty
  - bit 4: TX full
  - bit 5: overrun
  - bit 6: framing error
  - bit 7: parity error
  - bit 8: RX timeout
- R7: A write to address 3 clears every status bit whose data bit is one. Status bits whose data bit is zero keep their value.
- R8: When a cause is high in the same cycle as a write that clears its status bit, the bit stays set.
- R9: `irq_o` equals the OR of (status AND mask) as it stood one cycle earlier. Status bits that are masked off never raise `irq_o`.
- R10: A read of address 4 returns the live cause inputs for bits 0, 1, 3 and 4 (RX trigger, RX empty, TX empty, TX full), regardless of the mask. All other bits of that read are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 3 | Register address, used for both writes and reads |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| cause_i | input | 13 | Cause inputs from the UART paths |
| irq_o | output | 1 | Registered interrupt request |

## Verification
On every cycle, the assertions check four things:
- mask bits change only through the set and clear addresses;
- status bits never drop without a clear write;
- a high cause always lands in status, even against a clear;
- the interrupt line follows masked status one cycle later.

Only the bench scenarios can show the rest:
- that each individual bit reaches the interrupt alone;
- that ignored upper data bits leave the state untouched;
- that the live view picks exactly the four FIFO conditions.

The bench does this by sweeping every bit position and a series of mixed set, clear and event patterns against an arithmetic model.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int unsigned REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        A_ENABLE  = 3'd0,
        A_DISABLE = 3'd1,
        A_MASK    = 3'd2,
        A_STATUS  = 3'd3,
        A_LIVE    = 3'd4
    } irq_reg_e;

    // cause bit positions
    localparam int unsigned B_RXTRIG  = 0;
    localparam int unsigned B_RXEMPTY = 1;
    localparam int unsigned B_RXFULL  = 2;
    localparam int unsigned B_TXEMPTY = 3;
    localparam int unsigned B_TXFULL  = 4;
    localparam int unsigned B_OVERRUN = 5;
    localparam int unsigned B_FRAMING = 6;
    localparam int unsigned B_PARITY  = 7;
    localparam int unsigned B_RXTOUT  = 8;

endpackage

// File: rtl/uart_irq_mask.sv
module uart_irq_mask #(
    parameter int unsigned W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] mask_o
);
    typedef struct packed {
        logic [W-1:0] mask;
    } mask_st_t;

    mask_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.mask = (st_q.mask | set_i) & ~clr_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.mask;
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status #(
    parameter int unsigned W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cause_i,
    input  logic [W-1:0] clr_i,
    input  logic [W-1:0] mask_i,
    output logic [W-1:0] status_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [W-1:0] status;
        logic         irq;
    } stat_st_t;

    stat_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        // a cause in the clearing cycle keeps its bit
        st_d.status = (st_q.status & ~clr_i) | cause_i;
        st_d.irq    = |(st_q.status & mask_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;
    assign irq_o    = st_q.irq;
endmodule

// File: rtl/uart_irq_rdmux.sv
module uart_irq_rdmux
    import uart_irq_pkg::*;
#(
    parameter int unsigned W      = 13,
    parameter int unsigned DATA_W = 32
) (
    input  logic [REG_AW-1:0] addr,
    input  logic [W-1:0]      mask_i,
    input  logic [W-1:0]      status_i,
    input  logic [W-1:0]      cause_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam logic [W-1:0] LIVE_SEL = (W'(1) << B_RXTRIG)  | (W'(1) << B_RXEMPTY) |
                                        (W'(1) << B_TXEMPTY) | (W'(1) << B_TXFULL);

    always_comb begin
        rd_data_o = '0;
        case (addr)
            A_MASK:   rd_data_o = DATA_W'(mask_i);
            A_STATUS: rd_data_o = DATA_W'(status_i);
            A_LIVE:   rd_data_o = DATA_W'(cause_i & LIVE_SEL);
            default:  rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int unsigned W      = 13,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    input  logic [W-1:0]      cause_i,
    output logic              irq_o
);
    logic [W-1:0] set_w, dis_w, sclr_w;
    logic [W-1:0] mask_w, status_w;
    logic         unused_hi;

    assign unused_hi = ^wdata[DATA_W-1:W];

    always_comb begin
        set_w  = '0;
        dis_w  = '0;
        sclr_w = '0;
        if (wr_en) begin
            case (addr)
                A_ENABLE:  set_w  = wdata[W-1:0];
                A_DISABLE: dis_w  = wdata[W-1:0];
                A_STATUS:  sclr_w = wdata[W-1:0];
                default: ;
            endcase
        end
    end

    uart_irq_mask #(.W(W)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_w),
        .clr_i  (dis_w),
        .mask_o (mask_w)
    );

    uart_irq_status #(.W(W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .cause_i  (cause_i),
        .clr_i    (sclr_w),
        .mask_i   (mask_w),
        .status_o (status_w),
        .irq_o    (irq_o)
    );

    uart_irq_rdmux #(.W(W), .DATA_W(DATA_W)) u_rd (
        .addr      (addr),
        .mask_i    (mask_w),
        .status_i  (status_w),
        .cause_i   (cause_i),
        .rd_data_o (rd_data)
    );
endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk
    import uart_irq_pkg::*;
#(
    parameter int unsigned W      = 13,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [REG_AW-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rd_data,
    input logic [W-1:0]      cause_i,
    input logic [W-1:0]      mask_q,
    input logic [W-1:0]      status_q,
    input logic              irq_o
);
    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_ENABLE) |=> ((mask_q & $past(wdata[W-1:0])) == $past(wdata[W-1:0]))); // R2

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == A_ENABLE || addr == A_DISABLE)) |=> $stable(mask_q)); // R2

    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_DISABLE) |=> ((mask_q & $past(wdata[W-1:0])) == '0)); // R3

    AST_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_ENABLE || addr == A_DISABLE) |-> (rd_data == '0)); // R4

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_STATUS) |=> ((status_q & $past(status_q)) == $past(status_q))); // R6

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_i != '0) |=> ((status_q & $past(cause_i)) == $past(cause_i))); // R8

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & mask_q) != '0) |=> irq_o); // R9

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & mask_q) == '0) |=> !irq_o); // R9
endmodule

bind uart_irq_ctrl uart_irq_chk #(.W(W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rd_data  (rd_data),
    .cause_i  (cause_i),
    .mask_q   (mask_w),
    .status_q (status_w),
    .irq_o    (irq_o)
);

// File: tb/sim_uart_irq_ctrl.sv
module sim_uart_irq_ctrl;
    localparam int W = 13;
    localparam logic [31:0] ALL = 32'h0000_1FFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_data;
    logic [W-1:0] cause = '0;
    logic        irq;

    int total = 0;
    int bad = 0;
    logic [W-1:0] exp_mask = '0;
    logic [W-1:0] exp_stat = '0;

    always #5 clk = ~clk;

    uart_irq_ctrl u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rd_data (rd_data),
        .cause_i (cause),
        .irq_o   (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic pulse(input logic [W-1:0] c);
        @(negedge clk);
        cause = c;
        @(negedge clk);
        cause = '0;
    endtask

    task automatic chk_irq(input string req);
        @(negedge clk);
        chk(req, {31'd0, irq}, {31'd0, |(exp_stat & exp_mask)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd2, v); chk("R1 mask", v, 0);
        rd(3'd3, v); chk("R1 status", v, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R5 upper data bits ignored
        wr(3'd0, 32'hFFFF_E000);
        rd(3'd2, v); chk("R5 upper ignored", v, 0);

        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd2, v); chk("R5 mask width", v, ALL);
        rd(3'd0, v); chk("R4 enable reads zero", v, 0);
        rd(3'd1, v); chk("R4 disable reads zero", v, 0);

        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd2, v); chk("R3 disable all", v, 0);

        // per-bit sweep
        for (int i = 0; i < W; i++) begin
            exp_mask = W'(1) << i;
            wr(3'd0, 32'(exp_mask));
            rd(3'd2, v); chk("R2 single enable", v, 32'(exp_mask));

            exp_stat = '1;
            pulse('1);
            rd(3'd3, v); chk("R6 sticky after event", v, ALL);
            chk_irq("R9 irq on masked bit");

            exp_stat = exp_stat & ~(W'(1) << i);
            wr(3'd3, 32'(W'(1) << i));
            rd(3'd3, v); chk("R7 w1c single", v, 32'(exp_stat));
            chk_irq("R9 unmasked bits quiet");

            wr(3'd3, 32'hFFFF_FFFF);
            exp_stat = '0;
            rd(3'd3, v); chk("R7 clear all", v, 0);

            wr(3'd1, 32'(W'(1) << i));
            exp_mask = '0;
            rd(3'd2, v); chk("R3 single disable", v, 0);
        end

        // mixed patterns
        for (int k = 0; k < 16; k++) begin
            logic [W-1:0] p, q;
            p = W'(k * 165 + 7);
            q = W'(k * 307);

            wr(3'd0, 32'(p) | 32'hABC0_0000);
            exp_mask = exp_mask | p;
            wr(3'd1, 32'(q));
            exp_mask = exp_mask & ~q;
            rd(3'd2, v); chk("R2 R3 pattern mask", v, 32'(exp_mask));

            pulse(q);
            exp_stat = exp_stat | q;
            wr(3'd3, 32'(p));
            exp_stat = exp_stat & ~p;
            rd(3'd3, v); chk("R6 R7 pattern status", v, 32'(exp_stat));
            chk_irq("R9 pattern irq");
        end

        // R8 event wins over a clear in the same cycle
        wr(3'd3, 32'hFFFF_FFFF);
        pulse(W'(1) << 6);
        @(negedge clk);
        cause = W'(1) << 5;
        wr_en = 1'b1;
        addr  = 3'd3;
        wdata = (32'd1 << 5) | (32'd1 << 6);
        @(negedge clk);
        wr_en = 1'b0;
        cause = '0;
        rd(3'd3, v); chk("R8 event beats clear", v, 32'd1 << 5);

        // R10 live view, independent of the mask
        wr(3'd1, 32'hFFFF_FFFF);
        @(negedge clk);
        cause = '1;
        rd(3'd4, v); chk("R10 live all", v, 32'h1B);

        @(negedge clk);
        cause = W'(13'h00A);
        rd(3'd4, v); chk("R10 live subset", v, 32'h0A);

        @(negedge clk);
        cause = W'(13'h1E4);
        rd(3'd4, v); chk("R10 live others hidden", v, 0);

        @(negedge clk);
        cause = '0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule